// File: doc/BRIEF.md
# Rate-Driven PHY Test-Port Bring-Up Sequencer

This block brings a receive D-PHY out of reset and programs it through its serial test port. A one-cycle start pulse carries the lane data rate in Mbit/s, the number of active data lanes and two timing settings. The block looks up a frequency-range code by scanning an ascending table of rate upper bounds. It then sets the lane and mode controls, pulses the test-port clear with the test clock held high, and issues a fixed, ordered series of seven register writes over the test port. At the end it raises a one-cycle done pulse.

Every pin change is held for a programmable number of cycles so that the PHY sees setup and hold time around each test-clock edge. The two clear waits use a separate, longer count. A lane count outside the supported range is refused with an error pulse, and the test port stays untouched.

Top module: `phy_bringup_seq`

## Requirements
- R1: While reset is asserted and after it, until the first accepted start: busy, done and error are 0; test clock, clear and address-select are 0; test data, lane enables, turn-disable and turn-request are 0; force-receive and force-stop are 1; the range code output is 0.
- R2: On an accepted start the range code output takes, from the next cycle, the code of the first table entry (ascending upper bound) whose bound is at least the rate; the table starts 89→0x00, 99→0x10, 109→0x20, 129→0x01, 139→0x11 and ends 949→0x0A, 999→0x1A; a rate above 999 gives 0x00.
- R3: The first step after an accepted start clears force-receive, force-stop and turn-request, sets turn-disable to all ones (0xF for four lanes) and sets lane enables to the low n bits for n lanes.
- R4: The second step raises the test clock; the third raises clear for the wait count; the fourth drops clear for the wait count, with the test clock high throughout the clear pulse.
- R5: Seven writes follow as (address, data): (0x34, 0), (0x44, code shifted left by one), (0x54, 0), (0x84, 0), (0x94, 0), (0x75, 0x04), (0x00, 0). The address is the test data at a falling test-clock edge; the data is the test data at the next rising edge with address-select low.
- R6: Each write is the ordered pin series: clock high, data bus to address, address-select high, clock low, address-select low, data bus to data, clock high, one pin change per step.
- R7: Every step other than the two clear waits lasts the hold count; the clear waits last the wait count; a count of 0 acts as 1. Both counts are taken at the accepted start.
- R8: Busy is high from the cycle after the accepted start for exactly 51·hold + 2·wait cycles; in the next cycle busy is low and done is high for one cycle.
- R9: A start while busy is ignored: code, pin sequence and busy length are unchanged.
- R10: A start with a lane count of 0 or above 4 gives a one-cycle error pulse in the next cycle, busy stays low and no pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| rate_i | input | RATE_W | Lane data rate in Mbit/s |
| lanes_i | input | LCNT_W | Number of data lanes |
| hold_i | input | HOLD_W | Cycles each pin change is held (0 acts as 1) |
| wait_i | input | WAIT_W | Cycles of each clear wait (0 acts as 1) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle refusal pulse for a bad lane count |
| code_o | output | 8 | Selected frequency-range code |
| tp_clear_o | output | 1 | Test-port clear |
| tp_clk_o | output | 1 | Test-port clock |
| tp_addr_sel_o | output | 1 | Test-port address select |
| tp_data_o | output | 8 | Test-port data bus |
| lane_en_o | output | LANES_N | Data lane enables |
| turn_off_o | output | LANES_N | Lane turnaround disables |
| turn_req_o | output | LANES_N | Lane turnaround requests |
| frc_rx_o | output | 1 | Force receive mode |
| frc_stop_o | output | 1 | Force stop state |

## Verification
The bench aims at rates exactly on a table bound and one above it, where an off-by-one compare would return the next range's code, and at a rate beyond the last bound, where a design without the fallback would hold a stale or wrong code. It runs hold and wait counts of zero, which a design lacking the floor of one would turn into a wrapped, near-endless wait. A start pulse in the middle of a sequence would, if accepted, restart the series and lengthen busy, and lane counts of 0 and 5 would, if accepted, drive the test port instead of raising the error. Written addresses and data are rebuilt from the clock edges alone, so a swapped pin order within a write shows up as a wrong address or a missing write.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  localparam int RANGE_N    = 29;
  localparam int PREP_N     = 4;
  localparam int WRITES_N   = 7;
  localparam int SUBSTEPS_N = 7;
  localparam int STEPS_N    = PREP_N + WRITES_N * SUBSTEPS_N;

  typedef enum logic [2:0] {
    ACT_SETUP = 3'd0,
    ACT_CLK   = 3'd1,
    ACT_CLR   = 3'd2,
    ACT_SEL   = 3'd3,
    ACT_DATA  = 3'd4
  } act_e;

  typedef struct packed {
    act_e       act;
    logic       val;
    logic [7:0] bus;
    logic       long_wait;
  } step_t;

  // Upper rate bound of table entry i, ascending.
  function automatic logic [10:0] range_bound(int i);
    case (i)
      0: return 11'd89;    1: return 11'd99;    2: return 11'd109;
      3: return 11'd129;   4: return 11'd139;   5: return 11'd149;
      6: return 11'd169;   7: return 11'd179;   8: return 11'd199;
      9: return 11'd219;   10: return 11'd239;  11: return 11'd249;
      12: return 11'd269;  13: return 11'd299;  14: return 11'd329;
      15: return 11'd359;  16: return 11'd399;  17: return 11'd449;
      18: return 11'd499;  19: return 11'd549;  20: return 11'd599;
      21: return 11'd649;  22: return 11'd699;  23: return 11'd749;
      24: return 11'd799;  25: return 11'd849;  26: return 11'd899;
      27: return 11'd949;  default: return 11'd999;
    endcase
  endfunction

  // Range code of table entry i.
  function automatic logic [7:0] range_code(int i);
    case (i)
      0: return 8'h00;   1: return 8'h10;   2: return 8'h20;
      3: return 8'h01;   4: return 8'h11;   5: return 8'h21;
      6: return 8'h02;   7: return 8'h12;   8: return 8'h22;
      9: return 8'h03;   10: return 8'h13;  11: return 8'h23;
      12: return 8'h04;  13: return 8'h14;  14: return 8'h05;
      15: return 8'h15;  16: return 8'h25;  17: return 8'h06;
      18: return 8'h16;  19: return 8'h07;  20: return 8'h17;
      21: return 8'h08;  22: return 8'h18;  23: return 8'h09;
      24: return 8'h19;  25: return 8'h29;  26: return 8'h39;
      27: return 8'h0a;  default: return 8'h1a;
    endcase
  endfunction

  // Test-port register address of write w.
  function automatic logic [7:0] write_addr(int w);
    case (w)
      0: return 8'h34;
      1: return 8'h44;
      2: return 8'h54;
      3: return 8'h84;
      4: return 8'h94;
      5: return 8'h75;
      default: return 8'h00;
    endcase
  endfunction

  // Data of write w for a given range code.
  function automatic logic [7:0] write_data(int w, logic [7:0] code);
    if (w == 1) return code << 1;
    if (w == 5) return 8'h04;
    return 8'h00;
  endfunction

endpackage

// File: rtl/rate_range_lut.sv
module rate_range_lut
  import phy_seq_pkg::*;
#(
  parameter int RATE_W = 11
) (
  input  logic [RATE_W-1:0] rate_i,
  output logic [7:0]        code_o
);

  logic [RANGE_N-1:0] hit;

  for (genvar g = 0; g < RANGE_N; g++) begin : g_cmp
    assign hit[g] = (32'(rate_i) <= 32'(range_bound(g)));
  end

  // Lowest matching entry wins; no match leaves code 0.
  always_comb begin
    code_o = 8'h00;
    for (int i = RANGE_N - 1; i >= 0; i--) begin
      if (hit[i]) code_o = range_code(i);
    end
  end

endmodule

// File: rtl/seq_step_rom.sv
module seq_step_rom
  import phy_seq_pkg::*;
#(
  parameter int STEP_W = 6
) (
  input  logic [STEP_W-1:0] idx_i,
  input  logic [7:0]        code_i,
  output step_t             step_o
);

  always_comb begin
    int rel;
    int wr;
    int sub;
    rel = int'(idx_i) - PREP_N;
    wr  = (rel < 0) ? 0 : rel / SUBSTEPS_N;
    sub = (rel < 0) ? 0 : rel % SUBSTEPS_N;
    step_o.act       = ACT_SETUP;
    step_o.val       = 1'b0;
    step_o.bus       = 8'h00;
    step_o.long_wait = 1'b0;
    if (rel < 0) begin
      case (int'(idx_i))
        0: step_o.act = ACT_SETUP;
        1: begin step_o.act = ACT_CLK; step_o.val = 1'b1; end
        2: begin step_o.act = ACT_CLR; step_o.val = 1'b1; step_o.long_wait = 1'b1; end
        default: begin step_o.act = ACT_CLR; step_o.val = 1'b0; step_o.long_wait = 1'b1; end
      endcase
    end else begin
      case (sub)
        0: begin step_o.act = ACT_CLK;  step_o.val = 1'b1; end
        1: begin step_o.act = ACT_DATA; step_o.bus = write_addr(wr); end
        2: begin step_o.act = ACT_SEL;  step_o.val = 1'b1; end
        3: begin step_o.act = ACT_CLK;  step_o.val = 1'b0; end
        4: begin step_o.act = ACT_SEL;  step_o.val = 1'b0; end
        5: begin step_o.act = ACT_DATA; step_o.bus = write_data(wr, code_i); end
        default: begin step_o.act = ACT_CLK; step_o.val = 1'b1; end
      endcase
    end
  end

endmodule

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
  import phy_seq_pkg::*;
#(
  parameter int RATE_W  = 11,
  parameter int HOLD_W  = 8,
  parameter int WAIT_W  = 16,
  parameter int LANES_N = 4,
  parameter int LCNT_W  = $clog2(LANES_N + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [RATE_W-1:0]  rate_i,
  input  logic [LCNT_W-1:0]  lanes_i,
  input  logic [HOLD_W-1:0]  hold_i,
  input  logic [WAIT_W-1:0]  wait_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               err_o,
  output logic [7:0]         code_o,
  output logic               tp_clear_o,
  output logic               tp_clk_o,
  output logic               tp_addr_sel_o,
  output logic [7:0]         tp_data_o,
  output logic [LANES_N-1:0] lane_en_o,
  output logic [LANES_N-1:0] turn_off_o,
  output logic [LANES_N-1:0] turn_req_o,
  output logic               frc_rx_o,
  output logic               frc_stop_o
);

  localparam int CNT_W  = (HOLD_W > WAIT_W) ? HOLD_W : WAIT_W;
  localparam int STEP_W = $clog2(STEPS_N);

  function automatic logic [CNT_W-1:0] floor_one(logic [CNT_W-1:0] v);
    return (v == '0) ? CNT_W'(1) : v;
  endfunction

  function automatic logic [LANES_N-1:0] low_mask(logic [LCNT_W-1:0] n);
    logic [LANES_N-1:0] m;
    m = '0;
    for (int i = 0; i < LANES_N; i++) if (i < int'(n)) m[i] = 1'b1;
    return m;
  endfunction

  logic              busy_q, done_q, err_q;
  logic [STEP_W-1:0] step_q;
  logic [7:0]        code_q;
  logic [CNT_W-1:0]  hold_q, wait_q;

  logic              lanes_ok_w, accept_w, reject_w;
  logic              tmr_zero_w, last_step_w, step_adv_w, finish_w, apply_w;
  logic [7:0]        lut_code_w, step_code_w;
  logic [STEP_W-1:0] step_sel_w;
  logic [CNT_W-1:0]  hold_use_w, wait_use_w, dur_w;
  step_t             step_w;

  assign lanes_ok_w  = (lanes_i != '0) && (int'(lanes_i) <= LANES_N);
  assign accept_w    = start_i && !busy_q && lanes_ok_w;
  assign reject_w    = start_i && !busy_q && !lanes_ok_w;
  assign last_step_w = (step_q == STEP_W'(STEPS_N - 1));
  assign step_adv_w  = busy_q && tmr_zero_w && !last_step_w;
  assign finish_w    = busy_q && tmr_zero_w && last_step_w;
  assign apply_w     = accept_w || step_adv_w;

  assign step_sel_w  = accept_w ? '0 : step_q + 1'b1;
  assign step_code_w = accept_w ? lut_code_w : code_q;
  assign hold_use_w  = accept_w ? floor_one(CNT_W'(hold_i)) : hold_q;
  assign wait_use_w  = accept_w ? floor_one(CNT_W'(wait_i)) : wait_q;
  assign dur_w       = step_w.long_wait ? wait_use_w : hold_use_w;

  rate_range_lut #(.RATE_W(RATE_W)) u_lut (
    .rate_i (rate_i),
    .code_o (lut_code_w)
  );

  seq_step_rom #(.STEP_W(STEP_W)) u_rom (
    .idx_i  (step_sel_w),
    .code_i (step_code_w),
    .step_o (step_w)
  );

  seq_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (apply_w),
    .val_i  (dur_w - 1'b1),
    .zero_o (tmr_zero_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q        <= 1'b0;
      done_q        <= 1'b0;
      err_q         <= 1'b0;
      step_q        <= '0;
      code_q        <= 8'h00;
      hold_q        <= CNT_W'(1);
      wait_q        <= CNT_W'(1);
      tp_clear_o    <= 1'b0;
      tp_clk_o      <= 1'b0;
      tp_addr_sel_o <= 1'b0;
      tp_data_o     <= 8'h00;
      lane_en_o     <= '0;
      turn_off_o    <= '0;
      turn_req_o    <= '0;
      frc_rx_o      <= 1'b1;
      frc_stop_o    <= 1'b1;
    end else begin
      done_q <= finish_w;
      err_q  <= reject_w;
      if (accept_w) begin
        busy_q <= 1'b1;
        step_q <= '0;
        code_q <= lut_code_w;
        hold_q <= hold_use_w;
        wait_q <= wait_use_w;
      end else if (step_adv_w) begin
        step_q <= step_q + 1'b1;
      end else if (finish_w) begin
        busy_q <= 1'b0;
      end
      if (apply_w) begin
        case (step_w.act)
          ACT_SETUP: begin
            frc_rx_o   <= 1'b0;
            frc_stop_o <= 1'b0;
            turn_req_o <= '0;
            turn_off_o <= '1;
            lane_en_o  <= low_mask(lanes_i);
          end
          ACT_CLK:  tp_clk_o      <= step_w.val;
          ACT_CLR:  tp_clear_o    <= step_w.val;
          ACT_SEL:  tp_addr_sel_o <= step_w.val;
          default:  tp_data_o     <= step_w.bus;
        endcase
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign err_o  = err_q;
  assign code_o = code_q;

endmodule

// File: rtl/phy_bringup_seq_chk.sv
module phy_bringup_seq_chk #(
  parameter int LANES_N = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy_o,
  input logic               done_o,
  input logic               err_o,
  input logic               tp_clk_o,
  input logic               tp_clear_o,
  input logic               tp_addr_sel_o,
  input logic [7:0]         tp_data_o,
  input logic [LANES_N-1:0] lane_en_o,
  input logic               accept_w
);

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o))); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8

  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!busy_o && $stable(tp_clk_o) && $stable(tp_data_o)
               && $stable(tp_addr_sel_o) && $stable(tp_clear_o))); // R10

  AST_CLEAR_UNDER_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    tp_clear_o |-> tp_clk_o); // R4

  AST_SEL_RISE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tp_addr_sel_o) |-> tp_clk_o); // R6

  AST_CLK_FALL_WITH_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tp_clk_o) |-> tp_addr_sel_o); // R6

  AST_ONE_PIN_PER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!$stable(tp_clk_o), !$stable(tp_clear_o),
                !$stable(tp_addr_sel_o), !$stable(tp_data_o)}) <= 1); // R6

  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !accept_w) |=> ($stable(tp_clk_o) && $stable(tp_data_o)
                                && $stable(lane_en_o))); // R9

endmodule

bind phy_bringup_seq phy_bringup_seq_chk #(.LANES_N(LANES_N)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .err_o         (err_o),
  .tp_clk_o      (tp_clk_o),
  .tp_clear_o    (tp_clear_o),
  .tp_addr_sel_o (tp_addr_sel_o),
  .tp_data_o     (tp_data_o),
  .lane_en_o     (lane_en_o),
  .accept_w      (accept_w)
);

// File: tb/phy_bringup_seq_test.sv
`timescale 1ns/1ps
module phy_bringup_seq_test;

  localparam int RATE_W = 11, HOLD_W = 8, WAIT_W = 16, LANES_N = 4, LCNT_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              start = 1'b0;
  logic [RATE_W-1:0] rate = '0;
  logic [LCNT_W-1:0] lanes = '0;
  logic [HOLD_W-1:0] hold = '0;
  logic [WAIT_W-1:0] waitc = '0;

  logic busy_o, done_o, err_o, tp_clear_o, tp_clk_o, tp_addr_sel_o, frc_rx_o, frc_stop_o;
  logic [7:0] code_o, tp_data_o;
  logic [LANES_N-1:0] lane_en_o, turn_off_o, turn_req_o;

  phy_bringup_seq #(.RATE_W(RATE_W), .HOLD_W(HOLD_W), .WAIT_W(WAIT_W), .LANES_N(LANES_N)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .rate_i(rate), .lanes_i(lanes),
    .hold_i(hold), .wait_i(waitc), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .code_o(code_o), .tp_clear_o(tp_clear_o), .tp_clk_o(tp_clk_o),
    .tp_addr_sel_o(tp_addr_sel_o), .tp_data_o(tp_data_o), .lane_en_o(lane_en_o),
    .turn_off_o(turn_off_o), .turn_req_o(turn_req_o), .frc_rx_o(frc_rx_o),
    .frc_stop_o(frc_stop_o)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Reference range lookup, written as a scan over bound/code pairs.
  function automatic int ref_code(int r);
    int ub[] = '{89, 99, 109, 129, 139, 149, 169, 179, 199, 219, 239, 249, 269, 299,
                 329, 359, 399, 449, 499, 549, 599, 649, 699, 749, 799, 849, 899, 949, 999};
    int cd[] = '{'h00, 'h10, 'h20, 'h01, 'h11, 'h21, 'h02, 'h12, 'h22, 'h03, 'h13, 'h23,
                 'h04, 'h14, 'h05, 'h15, 'h25, 'h06, 'h16, 'h07, 'h17, 'h08, 'h18, 'h09,
                 'h19, 'h29, 'h39, 'h0a, 'h1a};
    foreach (ub[k]) if (r <= ub[k]) return cd[k];
    return 0;
  endfunction

  // Behavioural reference: a queue of pin states with durations.
  typedef struct {
    bit clk_; bit clr; bit sel; int bus; int len; int toff; int treq; bit frx; bit fst; int dur;
  } ms_t;

  ms_t mq[$];
  ms_t m;
  int  m_rem = 0;
  bit  m_busy = 0, m_done = 0, m_err = 0;
  int  m_code = 0;

  task automatic m_reset();
    m.clk_ = 0; m.clr = 0; m.sel = 0; m.bus = 0; m.len = 0; m.toff = 0; m.treq = 0;
    m.frx = 1; m.fst = 1; m.dur = 0;
    mq.delete(); m_rem = 0; m_busy = 0; m_done = 0; m_err = 0; m_code = 0;
  endtask

  task automatic m_build(int code, int n, int h, int w);
    ms_t c;
    int addr[7] = '{'h34, 'h44, 'h54, 'h84, 'h94, 'h75, 'h00};
    int dat[7];
    dat = '{0, (code * 2) & 'hff, 0, 0, 0, 4, 0};
    c = m;
    c.frx = 0; c.fst = 0; c.treq = 0; c.toff = 'hf; c.len = (1 << n) - 1; c.dur = h;
    mq.push_back(c);
    c.clk_ = 1; mq.push_back(c);
    c.clr = 1; c.dur = w; mq.push_back(c);
    c.clr = 0; mq.push_back(c);
    c.dur = h;
    for (int k = 0; k < 7; k++) begin
      c.clk_ = 1; mq.push_back(c);
      c.bus = addr[k]; mq.push_back(c);
      c.sel = 1; mq.push_back(c);
      c.clk_ = 0; mq.push_back(c);
      c.sel = 0; mq.push_back(c);
      c.bus = dat[k]; mq.push_back(c);
      c.clk_ = 1; mq.push_back(c);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_reset();
    end else begin
      m_done = 0;
      m_err = 0;
      if (!m_busy) begin
        if (start) begin
          if (lanes == 0 || lanes > 4) begin
            m_err = 1;
          end else begin
            m_code = ref_code(int'(rate));
            m_build(m_code, int'(lanes), (hold == 0) ? 1 : int'(hold),
                    (waitc == 0) ? 1 : int'(waitc));
            m = mq.pop_front();
            m_rem = m.dur;
            m_busy = 1;
          end
        end
      end else begin
        m_rem--;
        if (m_rem == 0) begin
          if (mq.size() == 0) begin
            m_busy = 0;
            m_done = 1;
          end else begin
            m = mq.pop_front();
            m_rem = m.dur;
          end
        end
      end
    end
  end

  // Every-cycle comparison against the reference, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy_o == m_busy, "R8", "busy", busy_o, m_busy);
      chk(done_o == m_done, "R8", "done", done_o, m_done);
      chk(err_o == m_err, "R10", "err", err_o, m_err);
      chk(int'(code_o) == m_code, "R2", "code", code_o, m_code);
      chk(tp_clk_o == m.clk_, "R6", "test clock", tp_clk_o, m.clk_);
      chk(tp_clear_o == m.clr, "R4", "clear", tp_clear_o, m.clr);
      chk(tp_addr_sel_o == m.sel, "R6", "address select", tp_addr_sel_o, m.sel);
      chk(int'(tp_data_o) == m.bus, "R6", "data bus", tp_data_o, m.bus);
      chk(int'(lane_en_o) == m.len, "R3", "lane enables", lane_en_o, m.len);
      chk(int'(turn_off_o) == m.toff, "R3", "turn disable", turn_off_o, m.toff);
      chk(int'(turn_req_o) == m.treq, "R3", "turn request", turn_req_o, m.treq);
      chk(frc_rx_o == m.frx, "R3", "force receive", frc_rx_o, m.frx);
      chk(frc_stop_o == m.fst, "R3", "force stop", frc_stop_o, m.fst);
    end
  end

  // Protocol-level capture of writes from the test-clock edges.
  logic p_clk = 1'b0;
  bit   pend = 0;
  int   wa = 0;
  int   wlog[$];
  always @(negedge clk) begin
    if (rst_n) begin
      if (p_clk && !tp_clk_o) begin
        wa = int'(tp_data_o);
        pend = 1;
      end else if (!p_clk && tp_clk_o && pend && !tp_addr_sel_o) begin
        wlog.push_back((wa << 8) | int'(tp_data_o));
        pend = 0;
      end
      p_clk = tp_clk_o;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL R8 watchdog: actual %0d cycles expected below 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run(int r, int n, int h, int w, int exp_code, bit mid);
    int he = (h == 0) ? 1 : h;
    int we = (w == 0) ? 1 : w;
    int cnt = 0;
    int clr_cnt = 0;
    int exp_w[7];
    exp_w = '{'h3400, 'h4400 | ((exp_code * 2) & 'hff), 'h5400, 'h8400, 'h9400, 'h7504, 'h0000};
    wlog.delete();
    @(negedge clk);
    rate = RATE_W'(r); lanes = LCNT_W'(n); hold = HOLD_W'(h); waitc = WAIT_W'(w);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R3: setup step visible in the first busy cycle
    chk(int'(lane_en_o) == (1 << n) - 1, "R3", "lane mask after start", lane_en_o, (1 << n) - 1);
    chk(turn_off_o == 4'hf && !frc_rx_o && !frc_stop_o, "R3", "mode controls after start",
        {turn_off_o, frc_rx_o, frc_stop_o}, 'h3c);
    while (!done_o && cnt < 100000) begin
      if (busy_o) cnt++;
      if (tp_clear_o) clr_cnt++;
      start = (mid && cnt == 10) ? 1'b1 : 1'b0;   // R9: start during busy
      if (mid && cnt == 10) begin rate = 11'd999; lanes = 3'd1; end
      @(negedge clk);
    end
    start = 1'b0;
    chk(cnt == 51 * he + 2 * we, "R8", "busy length (R7 counts, R9 ignore)", cnt, 51 * he + 2 * we);
    chk(clr_cnt == we, "R4", "clear pulse length", clr_cnt, we);
    chk(int'(code_o) == exp_code, "R2", "range code", code_o, exp_code);
    chk(wlog.size() == 7, "R5", "write count", wlog.size(), 7);
    for (int k = 0; k < 7; k++) begin
      int got = (k < wlog.size()) ? wlog[k] : -1;
      chk(got == exp_w[k], "R5", "write addr/data", got, exp_w[k]);
    end
  endtask

  task automatic run_bad(int n);
    logic c0;
    logic [7:0] d0;
    @(negedge clk);
    c0 = tp_clk_o; d0 = tp_data_o;
    lanes = LCNT_W'(n); rate = 11'd300; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(err_o == 1'b1, "R10", "error pulse", err_o, 1);
    chk(busy_o == 1'b0, "R10", "busy after refusal", busy_o, 0);
    @(negedge clk);
    chk(err_o == 1'b0, "R10", "error is one cycle", err_o, 0);
    chk(tp_clk_o == c0 && tp_data_o == d0, "R10", "test port unchanged",
        {tp_clk_o, tp_data_o}, {c0, d0});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy_o && !done_o && !err_o, "R1", "status in reset", {busy_o, done_o, err_o}, 0);
    chk(!tp_clk_o && !tp_clear_o && !tp_addr_sel_o && tp_data_o == 0, "R1", "test port in reset",
        {tp_clk_o, tp_clear_o, tp_addr_sel_o, tp_data_o}, 0);
    chk(lane_en_o == 0 && turn_off_o == 0 && turn_req_o == 0, "R1", "lane controls in reset",
        {lane_en_o, turn_off_o, turn_req_o}, 0);
    chk(frc_rx_o && frc_stop_o && code_o == 0, "R1", "force flags and code in reset",
        {frc_rx_o, frc_stop_o, code_o}, 'h300);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy_o && frc_rx_o && lane_en_o == 0, "R1", "idle after reset", {busy_o, frc_rx_o}, 1);

    run(80, 4, 1, 3, 'h00, 0);      // R2 low rate
    run(95, 2, 2, 5, 'h10, 1);      // R2, R9 start while busy
    run(130, 1, 1, 2, 'h11, 0);     // R2 between bounds
    run(89, 3, 1, 1, 'h00, 0);      // R2 exact bound
    run(90, 4, 1, 1, 'h10, 0);      // R2 one above bound
    run(999, 3, 1, 2, 'h1a, 0);     // R2 last bound
    run(1000, 2, 1, 1, 'h00, 0);    // R2 beyond table
    run(500, 4, 0, 0, 'h07, 0);     // R7 zero counts act as one
    run_bad(0);                     // R10
    run_bad(5);                     // R10
    run(300, 1, 3, 4, 'h05, 0);     // R6 longer hold

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule